// File: doc/BRIEF.md
# Dual-Hit Pixel Time-Stamp Front-End

This block is the digital part of one pixel in a sparsified pixel matrix. A discriminator output from the analog front-end arrives without timing constraints and is synchronized inside the block. Each rising edge counts as one hit. The pixel keeps up to two hits. Each hit has its own latch and a time-stamp register of `TS_W` bits. While a latch is empty, its register follows the shared time-stamp bus. When the hit is taken, the register freezes at the current bus value. A per-pixel kill bit stops a noisy pixel from recording anything.

Operation follows the collider duty cycle. While `train_i` is high (the bunch-train window), the pixel acquires hits. While `train_i` is low (the gap between trains), it raises a request to the matrix readout. It then presents its stored hits one at a time, the earlier hit first, and drops each one when the readout acknowledges it. A new train clears anything left over. Hits beyond the second one in a train are lost, and an overflow flag records that this happened.

Top module: `pix_dualhit_fe`

## Requirements
- R1: After reset, `rd_req_o` is 0, `ovf_o` is 0 and `rd_ts_o` is 0.
- R2: The first accepted hit of a train stores the bus value that is present two clock edges after the discriminator rises. Later bus changes do not alter the stored value. The hit is presented first, with `rd_slot_o` = 0.
- R3: A second accepted hit stores its own time stamp in the second slot. This hit is presented after the first one has been acknowledged, with `rd_slot_o` = 1.
- R4: A hit that arrives while both slots are full is dropped, and `ovf_o` goes to 1 and stays at 1 until the next train begins.
- R5: A discriminator pulse that stays high for several clocks counts as exactly one hit.
- R6: While `kill_i` is 1, hits are not stored.
- R7: A discriminator pulse while `train_i` is 0 stores nothing.
- R8: `rd_req_o` is 1 only while `train_i` is 0 and at least one hit is stored. Whenever `rd_req_o` is 0, `rd_ts_o` and `rd_slot_o` are 0.
- R9: `rd_ack_i` while `rd_req_o` is 1 clears the presented hit at the next clock edge. `rd_ack_i` while `rd_req_o` is 0 has no effect.
- R10: A rising edge of `train_i` clears both slots and `ovf_o`. Unread hits are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disc_i | input | 1 | Discriminator output, asynchronous |
| ts_bus_i | input | TS_W | Shared time-stamp bus |
| train_i | input | 1 | 1 = acquisition window, 0 = readout gap |
| kill_i | input | 1 | Kill bit: 1 blocks hit capture |
| rd_ack_i | input | 1 | Readout acknowledge for the presented hit |
| rd_req_o | output | 1 | Readout request |
| rd_ts_o | output | TS_W | Time stamp of the presented hit |
| rd_slot_o | output | 1 | 0 = first hit presented, 1 = second hit presented |
| ovf_o | output | 1 | A hit was lost in this train |

## Verification
The assertions check several properties on every clock cycle:
- A frozen time stamp stays stable.
- Inside a train, the second slot never fills before the first.
- The overflow flag appears only when both slots are full.
- The edge detector never emits two pulses in a row.
- A slot never fills while the kill bit was high.
- An acknowledged hit is gone on the next cycle.

Some behaviours can only be shown by the bench scenarios. One is that the value read out equals the bus value at the moment of the hit, across random widths, masks and hit counts. Another is that first-before-second ordering holds across a full readout. The last is that leftovers are discarded when a new train starts.

// File: rtl/pix_fe_pkg.sv
package pix_fe_pkg;
    localparam int HIT_SLOTS = 2;

    typedef enum logic {
        SLOT_EARLY = 1'b0,
        SLOT_LATE  = 1'b1
    } slot_e;

    // oldest occupied slot wins the readout
    function automatic slot_e pick_slot(input logic [HIT_SLOTS-1:0] full);
        return full[0] ? SLOT_EARLY : SLOT_LATE;
    endfunction
endpackage

// File: rtl/pix_hit_sync.sv
module pix_hit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.chain[STAGES-1] & ~s_q.prev;

    // R5: an edge yields a single-cycle pulse
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/pix_hit_slot.sv
module pix_hit_slot #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            set_i,
    input  logic            rel_i,
    input  logic [TS_W-1:0] ts_bus_i,
    output logic            full_o,
    output logic [TS_W-1:0] ts_o
);
    typedef struct packed {
        logic            full;
        logic [TS_W-1:0] ts;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.full = 1'b0;
            s_d.ts   = '0;
        end else begin
            if (!s_q.full) s_d.ts = ts_bus_i;
            if (rel_i)     s_d.full = 1'b0;
            if (set_i)     s_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full_o = s_q.full;
    assign ts_o   = s_q.ts;

    // R2: a captured stamp does not move while the slot stays occupied
    p_frozen_ts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !clr_i && !rel_i) |=> $stable(ts_o));
endmodule

// File: rtl/pix_rd_sel.sv
module pix_rd_sel
    import pix_fe_pkg::*;
#(
    parameter int TS_W = 5
) (
    input  logic [HIT_SLOTS-1:0] full_i,
    input  logic [TS_W-1:0]      ts_i [HIT_SLOTS],
    input  logic                 train_i,
    input  logic                 ack_i,
    output logic                 req_o,
    output logic [TS_W-1:0]      ts_o,
    output logic                 slot_o,
    output logic [HIT_SLOTS-1:0] rel_o
);
    slot_e sel;

    always_comb begin
        sel    = pick_slot(full_i);
        req_o  = (|full_i) & ~train_i;
        ts_o   = '0;
        slot_o = 1'b0;
        rel_o  = '0;
        if (req_o) begin
            ts_o   = ts_i[sel];
            slot_o = sel;
            rel_o[sel] = ack_i;
        end
    end
endmodule

// File: rtl/pix_dualhit_fe.sv
module pix_dualhit_fe
    import pix_fe_pkg::*;
#(
    parameter int TS_W        = 5,
    parameter int SYNC_STAGES = 2,
    parameter bit OVF_EN      = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disc_i,
    input  logic [TS_W-1:0] ts_bus_i,
    input  logic            train_i,
    input  logic            kill_i,
    input  logic            rd_ack_i,
    output logic            rd_req_o,
    output logic [TS_W-1:0] rd_ts_o,
    output logic            rd_slot_o,
    output logic            ovf_o
);
    typedef struct packed {
        logic train;
        logic ovf;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                 hit_pulse;
    logic                 train_rise;
    logic                 accept;
    logic [HIT_SLOTS-1:0] full;
    logic [HIT_SLOTS-1:0] set_v;
    logic [HIT_SLOTS-1:0] rel_v;
    logic [TS_W-1:0]      ts_v [HIT_SLOTS];

    pix_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (disc_i),
        .pulse_o (hit_pulse)
    );

    assign train_rise = train_i & ~c_q.train;
    assign accept     = hit_pulse & train_i & ~kill_i & ~train_rise;

    // fixed fill order: slot 0 first, slot 1 only behind it
    always_comb begin
        set_v[0] = accept & ~full[0];
        set_v[1] = accept & full[0] & ~full[1];
    end

    genvar g;
    generate
        for (g = 0; g < HIT_SLOTS; g++) begin : g_slot
            pix_hit_slot #(.TS_W(TS_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr_i    (train_rise),
                .set_i    (set_v[g]),
                .rel_i    (rel_v[g]),
                .ts_bus_i (ts_bus_i),
                .full_o   (full[g]),
                .ts_o     (ts_v[g])
            );
        end
    endgenerate

    pix_rd_sel #(.TS_W(TS_W)) u_sel (
        .full_i  (full),
        .ts_i    (ts_v),
        .train_i (train_i),
        .ack_i   (rd_ack_i),
        .req_o   (rd_req_o),
        .ts_o    (rd_ts_o),
        .slot_o  (rd_slot_o),
        .rel_o   (rel_v)
    );

    always_comb begin
        c_d       = c_q;
        c_d.train = train_i;
        if (train_rise) begin
            c_d.ovf = 1'b0;
        end else if (OVF_EN && accept && (&full)) begin
            c_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ovf_o = c_q.ovf;

    // R3: inside a running train the late slot never fills ahead of the early one
    p_fill_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.train && train_i && full[1]) |-> full[0]);

    // R4: overflow inside a train implies both slots hold hits
    p_ovf_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.train && train_i && ovf_o) |-> (&full));

    // R6: a slot never fills on a cycle where the kill bit was set
    p_kill_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full[0]) |-> !$past(kill_i));

    // R9: an acknowledged early hit is gone on the next cycle
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_slot_o) |=> !full[0]);

    // R8: nothing is requested during acquisition
    p_no_req_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (train_i && $past(train_i)) |-> !rd_req_o);
endmodule

// File: tb/sim_pix_dualhit_fe.sv
`timescale 1ns/1ps
module sim_pix_dualhit_fe;
    localparam int TS_W = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            disc_i = 1'b0;
    logic [TS_W-1:0] ts_bus_i = '0;
    logic            train_i = 1'b0;
    logic            kill_i = 1'b0;
    logic            rd_ack_i = 1'b0;
    logic            rd_req_o;
    logic [TS_W-1:0] rd_ts_o;
    logic            rd_slot_o;
    logic            ovf_o;

    int n_run = 0;
    int n_fail = 0;
    int exp_ts[$];
    bit exp_ovf = 0;

    always #2.5 clk = ~clk;

    pix_dualhit_fe #(.TS_W(TS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .disc_i(disc_i), .ts_bus_i(ts_bus_i),
        .train_i(train_i), .kill_i(kill_i), .rd_ack_i(rd_ack_i),
        .rd_req_o(rd_req_o), .rd_ts_o(rd_ts_o), .rd_slot_o(rd_slot_o),
        .ovf_o(ovf_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model of acceptance: window open, not killed, slot free
    function automatic void model_hit(input int v, input bit msk);
        if (train_i && !msk) begin
            if (exp_ts.size() < 2) exp_ts.push_back(v);
            else exp_ovf = 1;
        end
    endfunction

    task automatic do_hit(input int v, input int width, input bit msk);
        @(negedge clk);
        ts_bus_i = v[TS_W-1:0];
        kill_i   = msk;
        disc_i   = 1'b1;
        model_hit(v, msk);
        repeat (width) @(negedge clk);
        disc_i = 1'b0;
        repeat (4) @(negedge clk);
        ts_bus_i = ts_bus_i + 5'd7; // move the bus after capture
        kill_i = 1'b0;
    endtask

    task automatic start_train();
        @(negedge clk);
        train_i = 1'b1;
        exp_ts.delete();
        exp_ovf = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        int idx;
        @(negedge clk);
        train_i = 1'b0;
        repeat (2) @(negedge clk);
        check(ovf_o == exp_ovf, "R4 overflow flag", ovf_o, exp_ovf);
        check(rd_req_o == (exp_ts.size() > 0), "R8 request", rd_req_o, exp_ts.size() > 0);
        idx = 0;
        while (exp_ts.size() > 0) begin
            check(rd_req_o == 1'b1, "R8 request while hits stored", rd_req_o, 1);
            check(rd_ts_o == exp_ts[0][TS_W-1:0], idx == 0 ? "R2 first stamp" : "R3 second stamp",
                  rd_ts_o, exp_ts[0]);
            check(rd_slot_o == idx[0], "R3 slot order", rd_slot_o, idx);
            rd_ack_i = 1'b1;
            @(negedge clk);
            rd_ack_i = 1'b0;
            void'(exp_ts.pop_front());
            idx++;
        end
        check(rd_req_o == 1'b0, "R9 drained", rd_req_o, 0);
        check(rd_ts_o == '0, "R8 idle stamp", rd_ts_o, 0);
        // R9: stray acknowledge with nothing stored
        rd_ack_i = 1'b1;
        @(negedge clk);
        rd_ack_i = 1'b0;
        check(rd_req_o == 1'b0, "R9 stray ack", rd_req_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check(rd_req_o == 0, "R1 reset request", rd_req_o, 0);
        check(ovf_o == 0, "R1 reset overflow", ovf_o, 0);
        check(rd_ts_o == 0, "R1 reset stamp", rd_ts_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R3 directed: two hits, wide pulse counted once (R5)
        start_train();
        do_hit(5'd3, 6, 0);
        do_hit(5'd29, 1, 0);
        drain();

        // R4: four hits, two dropped
        start_train();
        do_hit(5'd10, 2, 0);
        do_hit(5'd11, 2, 0);
        do_hit(5'd12, 2, 0);
        do_hit(5'd13, 1, 0);
        drain();

        // R6: killed pixel stores nothing
        start_train();
        do_hit(5'd20, 2, 1);
        do_hit(5'd21, 1, 1);
        drain();

        // R7: hits in the readout gap are ignored
        do_hit(5'd17, 2, 0);
        check(rd_req_o == 0, "R7 gap hit ignored", rd_req_o, 0);

        // R10: unread hits and overflow cleared by a new train
        start_train();
        do_hit(5'd1, 1, 0);
        do_hit(5'd2, 1, 0);
        do_hit(5'd4, 1, 0);
        @(negedge clk);
        train_i = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_req_o == 1, "R10 pending before restart", rd_req_o, 1);
        check(ovf_o == 1, "R4 overflow before restart", ovf_o, 1);
        start_train();
        @(negedge clk);
        train_i = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_req_o == 0, "R10 restart cleared slots", rd_req_o, 0);
        check(ovf_o == 0, "R10 restart cleared overflow", ovf_o, 0);

        // random trains
        for (int t = 0; t < 40; t++) begin
            int nh;
            start_train();
            nh = $urandom_range(0, 4);
            for (int h = 0; h < nh; h++) begin
                do_hit($urandom_range(0, 31), $urandom_range(1, 3), $urandom_range(0, 5) == 0);
            end
            drain();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule